// File: doc/BRIEF.md
# Cycle-Counting Interrupt Timer with Reload Latch

This block is the interrupt timer of a cartridge-style memory mapper. The CPU programs it by plain write strobes. Only the top nibble of the write address and the low nibble of the write data matter. Four nibble writes build a 16-bit reload value. A control write picks the counting width, turns counting on or off, and stores an enable-on-acknowledge bit. A separate acknowledge write clears the interrupt and copies that stored bit into the enable.

Once enabled, the counter moves up by one on each CPU-cycle pulse. In full-width mode it wraps from 0xFFFF. In narrow mode only the low byte counts, and the high byte stays fixed. On a wrap the counter takes its reload bits from the latch and sets a pending flag. The flag drives an active-low interrupt line until software acknowledges it.

Top module: `cyc_irq_timer`

## Requirements
- R1: A synchronous reset clears the latch, the counter, the mode, enable and enable-on-acknowledge bits and the pending flag, so irq_n reads 1.
- R2: A write with page 0x8, 0x9, 0xA or 0xB loads wr_data[3:0] into latch bits [3:0], [7:4], [11:8] or [15:12] respectively.
- R3: A write with page 0xC stores wr_data[2] as mode (1 = 8-bit), wr_data[1] as enable and wr_data[0] as enable-on-acknowledge, and clears the pending flag. When wr_data[1] is 1, all 16 counter bits load from the latch in either mode.
- R4: A write with page 0xD clears the pending flag, copies enable-on-acknowledge into enable, and leaves the counter unchanged.
- R5: While enable is 1, each cpu_cycle pulse adds one to the counter. While enable is 0, the counter holds.
- R6: In 16-bit mode, an increment from 0xFFFF sets the pending flag and reloads all 16 counter bits from the latch.
- R7: In 8-bit mode only the low byte counts and the high byte never changes. An increment from low byte 0xFF sets the pending flag and reloads only the low byte from latch bits [7:0].
- R8: Latch writes never change the counter.
- R9: irq_n is 0 exactly while the pending flag is set. Once set, the flag stays set until a page 0xC or 0xD write.
- R10: In a cycle with a page 0xC write, the counter does not increment. A reload requested by that write wins over a same-cycle cpu_cycle pulse.
- R11: When an overflow falls in the same cycle as a page 0xD write, the pending flag ends up set.
- R12: Writes with pages 0x0 to 0x7, 0xE or 0xF have no effect on the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_page | input | 4 | Top nibble of the CPU write address |
| wr_data | input | 4 | Low nibble of the CPU write data |
| cpu_cycle | input | 1 | One-cycle pulse per CPU cycle |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions assume that wr_en and cpu_cycle are sampled on the same clock as the timer, and that each register write lasts exactly one cycle. They also assume that reset is held for at least one edge before any property applies. The bench drives every input at the falling edge and holds each write strobe for a single cycle. Collisions are created on purpose only for a control write against a counting pulse and for an acknowledge against an overflow, the two orderings the requirements define.

// File: rtl/cit_pkg.sv
package cit_pkg;
    localparam int PAGE_W    = 4;
    localparam int CTRL_PAGE = 4;   // page 0xC after the top bit
    localparam int ACK_PAGE  = 5;   // page 0xD after the top bit

    typedef struct packed {
        logic mode8;
        logic en;
        logic en_on_ack;
        logic pend;
    } ctrl_state_t;
endpackage

// File: rtl/cit_decode.sv
module cit_decode
    import cit_pkg::*;
#(
    parameter int NUM_NIB = 4
) (
    input  logic               wr_en,
    input  logic [PAGE_W-1:0]  wr_page,
    output logic [NUM_NIB-1:0] latch_we,
    output logic               ctrl_we,
    output logic               ack_we
);
    localparam int SUB_W = PAGE_W - 1;

    logic [SUB_W-1:0] sub;
    assign sub = wr_page[SUB_W-1:0];

    always_comb begin
        latch_we = '0;
        ctrl_we  = 1'b0;
        ack_we   = 1'b0;
        if (wr_en && wr_page[PAGE_W-1]) begin
            for (int i = 0; i < NUM_NIB; i++) begin
                if (int'(sub) == i) latch_we[i] = 1'b1;
            end
            if (int'(sub) == CTRL_PAGE) ctrl_we = 1'b1;
            if (int'(sub) == ACK_PAGE)  ack_we  = 1'b1;
        end
    end

    // R12: at most one register is addressed per write
    always_comb begin
        a_onehot_r12: assert ($onehot0({latch_we, ctrl_we, ack_we}));
    end
endmodule

// File: rtl/cit_latch.sv
module cit_latch #(
    parameter int CNT_W   = 16,
    parameter int NIB_W   = 4,
    localparam int NUM_NIB = CNT_W / NIB_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_NIB-1:0] latch_we,
    input  logic [NIB_W-1:0]   nib_in,
    output logic [CNT_W-1:0]   latch_q
);
    logic [CNT_W-1:0] latch_d;

    always_comb begin
        latch_d = latch_q;
        for (int i = 0; i < NUM_NIB; i++) begin
            if (latch_we[i]) latch_d[i*NIB_W +: NIB_W] = nib_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) latch_q <= '0;
        else     latch_q <= latch_d;
    end

    // R2: no strobe, no change
    p_latch_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (latch_we == '0) |=> $stable(latch_q));
endmodule

// File: rtl/cit_ctrl.sv
module cit_ctrl
    import cit_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_we,
    input  logic       ack_we,
    input  logic [2:0] ctrl_bits,
    input  logic       ovf,
    output logic       mode8,
    output logic       en,
    output logic       pend
);
    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_we) begin
            st_d.mode8     = ctrl_bits[2];
            st_d.en        = ctrl_bits[1];
            st_d.en_on_ack = ctrl_bits[0];
            st_d.pend      = 1'b0;
        end
        if (ack_we) begin
            st_d.en   = st_q.en_on_ack;
            st_d.pend = 1'b0;
        end
        if (ovf) st_d.pend = 1'b1;   // a new event outranks the clear
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign mode8 = st_q.mode8;
    assign en    = st_q.en;
    assign pend  = st_q.pend;

    p_ack_copy_r4: assert property (@(posedge clk) disable iff (rst)
        (ack_we && !ctrl_we) |=> (st_q.en == $past(st_q.en_on_ack)));
    p_pend_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q.pend && !ctrl_we && !ack_we) |=> st_q.pend);
    p_ovf_sets_r11: assert property (@(posedge clk) disable iff (rst)
        ovf |=> st_q.pend);
    p_ctrl_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && !ovf) |=> !st_q.pend);
endmodule

// File: rtl/cit_counter.sv
module cit_counter #(
    parameter int CNT_W = 16,
    parameter int LOW_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             mode8,
    input  logic             load_full,
    input  logic [CNT_W-1:0] latch,
    output logic             ovf
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        ovf   = 1'b0;
        if (load_full) begin
            cnt_d = latch;
        end else if (inc) begin
            if (mode8) begin
                if (&cnt_q[LOW_W-1:0]) begin
                    ovf = 1'b1;
                    cnt_d[LOW_W-1:0] = latch[LOW_W-1:0];
                end else begin
                    cnt_d[LOW_W-1:0] = cnt_q[LOW_W-1:0] + 1'b1;
                end
            end else begin
                if (&cnt_q) begin
                    ovf   = 1'b1;
                    cnt_d = latch;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!inc && !load_full) |=> $stable(cnt_q));
    p_high_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (mode8 && !load_full) |=> $stable(cnt_q[CNT_W-1:LOW_W]));
    p_full_load_r3: assert property (@(posedge clk) disable iff (rst)
        load_full |=> (cnt_q == $past(latch)));
    p_wrap_reload_r6: assert property (@(posedge clk) disable iff (rst)
        (ovf && !mode8) |=> (cnt_q == $past(latch)));
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
    import cit_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NIB_W = 4,
    parameter int LOW_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic [NIB_W-1:0]  wr_data,
    input  logic              cpu_cycle,
    output logic              irq_n
);
    localparam int NUM_NIB = CNT_W / NIB_W;

    logic [NUM_NIB-1:0] latch_we;
    logic               ctrl_we, ack_we;
    logic [CNT_W-1:0]   latch_q;
    logic               mode8, en, pend, ovf, inc, load_full;

    cit_decode #(.NUM_NIB(NUM_NIB)) u_dec (
        .wr_en(wr_en), .wr_page(wr_page),
        .latch_we(latch_we), .ctrl_we(ctrl_we), .ack_we(ack_we));

    cit_latch #(.CNT_W(CNT_W), .NIB_W(NIB_W)) u_latch (
        .clk(clk), .rst(rst), .latch_we(latch_we),
        .nib_in(wr_data), .latch_q(latch_q));

    cit_ctrl u_ctrl (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ack_we(ack_we),
        .ctrl_bits(wr_data[2:0]), .ovf(ovf),
        .mode8(mode8), .en(en), .pend(pend));

    // R10: a control write stops counting for that cycle
    assign inc       = cpu_cycle && en && !ctrl_we;
    assign load_full = ctrl_we && wr_data[1];

    cit_counter #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_cnt (
        .clk(clk), .rst(rst), .inc(inc), .mode8(mode8),
        .load_full(load_full), .latch(latch_q), .ovf(ovf));

    assign irq_n = !pend;

    p_irq_release_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_n) |-> $past(ctrl_we || ack_we));
endmodule

// File: tb/cyc_irq_timer_tb_top.sv
module cyc_irq_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_page = '0;
    logic [3:0] wr_data = '0;
    logic       cpu_cycle = 1'b0;
    logic       irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    cyc_irq_timer dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_page(wr_page),
        .wr_data(wr_data), .cpu_cycle(cpu_cycle), .irq_n(irq_n));

    // {reload latch, mode8, pulses to interrupt}
    localparam logic [24:0] VEC [0:4] = '{
        {16'hFFF0, 1'b0, 8'd16},
        {16'hFFFF, 1'b0, 8'd1},
        {16'hFF80, 1'b0, 8'd128},
        {16'h12FD, 1'b1, 8'd3},
        {16'hA5FF, 1'b1, 8'd1}
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s irq_n actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] page, input logic [3:0] data, input logic cyc);
        @(negedge clk);
        wr_en = 1'b1; wr_page = page; wr_data = data; cpu_cycle = cyc;
        @(negedge clk);
        wr_en = 1'b0; cpu_cycle = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cpu_cycle = 1'b1;
            @(negedge clk); cpu_cycle = 1'b0;
        end
    endtask

    task automatic load_latch(input logic [15:0] v);
        for (int i = 0; i < 4; i++) wr(4'h8 + 4'(i), v[i*4 +: 4], 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset", irq_n, 1'b1);

        // R1: latch and counter are zero: 8-bit mode wraps after 256 pulses
        wr(4'hC, 4'b0110, 1'b0);
        pulse(255); check("R1 cleared count", irq_n, 1'b1);
        pulse(1);   check("R1 cleared count", irq_n, 1'b0);
        wr(4'hC, 4'b0000, 1'b0); check("R3 ctrl ack", irq_n, 1'b1);

        // table walk: R2, R6, R7, R4 periodic reload
        for (int k = 0; k < 5; k++) begin
            logic [15:0] lv; logic m; int p;
            lv = VEC[k][24:9]; m = VEC[k][8]; p = int'(VEC[k][7:0]);
            load_latch(lv);
            wr(4'hC, {1'b0, m, 1'b1, 1'b1}, 1'b0);
            pulse(p - 1); check("R2 R6 R7 before wrap", irq_n, 1'b1);
            pulse(1);     check("R6 R7 wrap", irq_n, 1'b0);
            wr(4'hD, 4'h0, 1'b0); check("R4 ack", irq_n, 1'b1);
            pulse(p - 1); check("R6 R7 reload period", irq_n, 1'b1);
            pulse(1);     check("R6 R7 reload wrap", irq_n, 1'b0);
            pulse(2);     check("R9 stays low", irq_n, 1'b0);
            wr(4'hC, 4'h0, 1'b0); check("R3 clears", irq_n, 1'b1);
        end

        // R7: high byte frozen in 8-bit mode
        load_latch(16'hFFFD);
        wr(4'hC, 4'b0110, 1'b0);
        pulse(3); check("R7 narrow wrap", irq_n, 1'b0);
        wr(4'hC, 4'b0001, 1'b0);   // 16-bit, disabled, A=1, no reload
        wr(4'hD, 4'h0, 1'b0);      // enable via A
        pulse(2); check("R7 high kept", irq_n, 1'b1);
        pulse(1); check("R7 high kept", irq_n, 1'b0);
        wr(4'hC, 4'h0, 1'b0);

        // R3: control write reloads all 16 bits even in 8-bit mode
        load_latch(16'hFFFE);
        wr(4'hC, 4'b0110, 1'b0);
        pulse(2); check("R3 narrow wrap", irq_n, 1'b0);
        wr(4'hC, 4'b0001, 1'b0);
        wr(4'hD, 4'h0, 1'b0);
        pulse(1); check("R3 full load", irq_n, 1'b1);
        pulse(1); check("R3 full load", irq_n, 1'b0);
        wr(4'hC, 4'h0, 1'b0);

        // R5 hold while disabled, R4 ack keeps count and copies A
        load_latch(16'hFFFC);
        wr(4'hC, 4'b0010, 1'b0);
        pulse(2);
        wr(4'hC, 4'b0001, 1'b0);
        pulse(10); check("R5 hold", irq_n, 1'b1);
        wr(4'hD, 4'h0, 1'b0);
        pulse(1); check("R4 count kept", irq_n, 1'b1);
        pulse(1); check("R4 R5 wrap", irq_n, 1'b0);
        wr(4'hC, 4'h0, 1'b0);

        // R8: latch writes leave the counter
        load_latch(16'hFFFE);
        wr(4'hC, 4'b0010, 1'b0);
        load_latch(16'h0000);
        pulse(1); check("R8 latch only", irq_n, 1'b1);
        pulse(1); check("R8 latch only", irq_n, 1'b0);
        wr(4'hC, 4'h0, 1'b0);

        // R12: ignored pages
        load_latch(16'hFFFE);
        wr(4'hC, 4'b0010, 1'b0);
        wr(4'h4, 4'h0, 1'b0);
        wr(4'h5, 4'h0, 1'b0);
        wr(4'hE, 4'hF, 1'b0);
        wr(4'hF, 4'h0, 1'b0);
        wr(4'h0, 4'h0, 1'b0);
        pulse(1); check("R12 ignored", irq_n, 1'b1);
        pulse(1); check("R12 ignored", irq_n, 1'b0);
        wr(4'hF, 4'h0, 1'b0);
        wr(4'h5, 4'h0, 1'b0);
        check("R12 R9 no ack", irq_n, 1'b0);
        wr(4'hC, 4'h0, 1'b0);

        // R10: reload wins over a same-cycle pulse
        load_latch(16'hFFFF);
        wr(4'hC, 4'b0010, 1'b1);
        check("R10 no count", irq_n, 1'b1);
        pulse(1); check("R10 reload wins", irq_n, 1'b0);
        wr(4'hC, 4'h0, 1'b0);

        // R11: overflow during acknowledge keeps pending
        wr(4'hC, 4'b0011, 1'b0);
        pulse(1); check("R11 setup", irq_n, 1'b0);
        wr(4'hD, 4'h0, 1'b1);
        check("R11 ovf beats ack", irq_n, 1'b0);
        wr(4'hD, 4'h0, 1'b0);
        check("R11 plain ack", irq_n, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule